// File: doc/BRIEF.md
# FIFO Occupancy Interrupt Generator

This block sits beside a serial port's transmit and receive queues and converts their fill levels into interrupt requests. It watches the two occupancy counts, compares each with a software-chosen threshold, notices receive writes that find the queue full, and accepts two receive line-error pulses. Every source is latched into a sticky status bit that software clears by writing ones. A per-bit enable mask gates each bit onto its own interrupt line, and a test register lets software force any status bit.

The transmit-side sources react to edges rather than levels. The transmit threshold source fires once when occupancy falls below the threshold. The transmit-empty source fires once when the queue drains to zero. Because of this, software can clear them and they stay clear while the queue stays low. The receive threshold source is level-driven and keeps setting its bit for as long as the queue holds at least the threshold.

The register port is a plain single-cycle write strobe with an address and data, plus a read path that answers in the same cycle. The receive write valid/ready pair is only observed here. A transfer happens when both are high. Valid high with ready low is a refused write, and the character is lost; the block never drives back-pressure itself.

Top module: `fifo_irq_events`

## Requirements
- R1: Status bit 0 (transmit threshold) sets only in the cycle after transmit occupancy changes from at-or-above the threshold to below it. The threshold select encodes 0→1, 1→4, 2→8, 3→16 entries. It does not set again while occupancy stays below.
- R2: Coming out of reset with an empty transmit queue, status bit 0 does not set.
- R3: Status bit 2 (transmit empty) sets one cycle after transmit occupancy goes from nonzero to zero. It does not set again while occupancy stays at zero. It also sets once right after reset if the queue is empty then.
- R4: Status bit 1 (receive threshold) is set whenever receive occupancy is at least the selected threshold, which uses the same 0→1, 1→4, 2→8, 3→16 encoding. A clear does not hold while the condition remains true.
- R5: Status bit 3 (receive overflow) sets one cycle after a cycle with receive write valid high and ready low. A valid write with ready high does not set it.
- R6: A pulse on the frame-error input sets status bit 4, and a pulse on the break-error input sets status bit 5.
- R7: Address 0 reads the status bits. Writing a 1 there clears that bit, and writing a 0 leaves it unchanged.
- R8: Address 1 is a read/write enable mask. Each interrupt output is status AND enable. Status bits set regardless of the enable.
- R9: A write to address 2 sets every status bit whose data bit is 1. Address 2 reads as zero.
- R10: When a set and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | 6 | Transmit queue occupancy, 0 to 32 |
| rx_level_i | input | 6 | Receive queue occupancy, 0 to 32 |
| tx_thr_sel_i | input | 2 | Transmit threshold select |
| rx_thr_sel_i | input | 2 | Receive threshold select |
| rx_wvalid_i | input | 1 | Receive queue write valid |
| rx_wready_i | input | 1 | Receive queue write ready |
| rx_frame_err_i | input | 1 | Frame error pulse |
| rx_break_err_i | input | 1 | Break error pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 test |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Register read data, same cycle |
| irq_o | output | 6 | Interrupt lines, one per status bit |

## Verification
The bench moves transmit occupancy to exactly the threshold and then one below it, for every select value. A design comparing with the wrong operator fires at the threshold, and one without edge detection sets the bit again after it has been cleared. It checks the first cycle after reset, where a wrongly reset history register raises a false threshold event or misses the empty event. It also holds receive occupancy above its threshold across a clear, and drives an overflow in the same cycle as a clear of that bit. A design that gave the clear priority would report those bits as empty.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int NUM_SRC = 6;

  // status/enable/test bit positions
  localparam int B_TX_THR   = 0;
  localparam int B_RX_THR   = 1;
  localparam int B_TX_EMPTY = 2;
  localparam int B_RX_OVF   = 3;
  localparam int B_FRAME    = 4;
  localparam int B_BREAK    = 5;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_TEST   = 2'd2
  } reg_sel_e;

  // 0 -> 1 entry, n -> 2^(n+1) entries
  function automatic int unsigned thr_entries(logic [1:0] sel);
    int unsigned sh;
    sh = int'(sel) + 1;
    if (sel == 2'd0) return 32'd1;
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/fifo_irq_level_cmp.sv
module fifo_irq_level_cmp
  import fifo_irq_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter bit BELOW = 1'b1
) (
  input  logic [CNT_W-1:0] level_i,
  input  logic [1:0]       sel_i,
  output logic             cond_o
);

  logic [CNT_W-1:0] thr;
  assign thr = CNT_W'(thr_entries(sel_i));

  generate
    if (BELOW) begin : g_below
      assign cond_o = level_i < thr;
    end else begin : g_at_or_above
      assign cond_o = level_i >= thr;
    end
  endgenerate

endmodule

// File: rtl/fifo_irq_edge.sv
module fifo_irq_edge #(
  parameter bit RST_PREV = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_PREV;
    else         prev_q <= cond_i;
  end

  assign rise_o = cond_i & ~prev_q;

endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] enable_o
);

  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end
  assign enable_o = en_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 1'b0;
      else         st_q <= set_i[b] | (st_q & ~clr_i[b]);
    end
    assign status_o[b] = st_q;

    // R10: a set in the same cycle as a clear leaves the bit high
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> status_o[b]);
    // R7: a clear with no competing set drops the bit
    a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[b] && !set_i[b]) |=> !status_o[b]);
  end

endmodule

// File: rtl/fifo_irq_events.sv
module fifo_irq_events
  import fifo_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 32,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   tx_level_i,
  input  logic [CNT_W-1:0]   rx_level_i,
  input  logic [1:0]         tx_thr_sel_i,
  input  logic [1:0]         rx_thr_sel_i,
  input  logic               rx_wvalid_i,
  input  logic               rx_wready_i,
  input  logic               rx_frame_err_i,
  input  logic               rx_break_err_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic [NUM_SRC-1:0] irq_o
);

  logic tx_thr_cond, rx_thr_cond, tx_empty_cond;
  logic tx_thr_evt, tx_empty_evt;
  logic [NUM_SRC-1:0] evt, set_vec, clr_vec, status, enable;
  logic wr_status, wr_enable, wr_test;

  fifo_irq_level_cmp #(.CNT_W(CNT_W), .BELOW(1'b1)) u_tx_cmp (
    .level_i (tx_level_i),
    .sel_i   (tx_thr_sel_i),
    .cond_o  (tx_thr_cond)
  );

  fifo_irq_level_cmp #(.CNT_W(CNT_W), .BELOW(1'b0)) u_rx_cmp (
    .level_i (rx_level_i),
    .sel_i   (rx_thr_sel_i),
    .cond_o  (rx_thr_cond)
  );

  assign tx_empty_cond = (tx_level_i == '0);

  // history starts high: an idle queue after reset is not a crossing
  fifo_irq_edge #(.RST_PREV(1'b1)) u_tx_thr_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (tx_thr_cond),
    .rise_o (tx_thr_evt)
  );

  // history starts low: an empty queue after reset reports once
  fifo_irq_edge #(.RST_PREV(1'b0)) u_tx_empty_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (tx_empty_cond),
    .rise_o (tx_empty_evt)
  );

  always_comb begin
    evt             = '0;
    evt[B_TX_THR]   = tx_thr_evt;
    evt[B_RX_THR]   = rx_thr_cond;
    evt[B_TX_EMPTY] = tx_empty_evt;
    evt[B_RX_OVF]   = rx_wvalid_i & ~rx_wready_i;
    evt[B_FRAME]    = rx_frame_err_i;
    evt[B_BREAK]    = rx_break_err_i;
  end

  assign wr_status = reg_we_i && (reg_addr_i == SEL_STATUS);
  assign wr_enable = reg_we_i && (reg_addr_i == SEL_ENABLE);
  assign wr_test   = reg_we_i && (reg_addr_i == SEL_TEST);

  assign clr_vec = wr_status ? reg_wdata_i : '0;
  assign set_vec = evt | (wr_test ? reg_wdata_i : '0);

  fifo_irq_status #(.N(NUM_SRC)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .en_we_i    (wr_enable),
    .en_wdata_i (reg_wdata_i),
    .status_o   (status),
    .enable_o   (enable)
  );

  always_comb begin
    unique case (reg_addr_i)
      SEL_STATUS: reg_rdata_o = status;
      SEL_ENABLE: reg_rdata_o = enable;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = status & enable;

  // R1: no second threshold event while occupancy stays below
  a_r1_tx_thr_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(tx_thr_cond) && tx_thr_cond) |-> !tx_thr_evt);
  // R3: no second empty event while the queue stays drained
  a_r3_tx_empty_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(tx_level_i) == '0 && tx_level_i == '0) |-> !tx_empty_evt);
  // R4: receive threshold condition lands in the status bit
  a_r4_rx_thr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_thr_cond |=> status[B_RX_THR]);
  // R5: refused receive write lands in the overflow bit
  a_r5_rx_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_wvalid_i && !rx_wready_i) |=> status[B_RX_OVF]);
  // R8: a masked source never reaches its line
  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~enable) == '0);

endmodule

// File: tb/fifo_irq_events_test.sv
module fifo_irq_events_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] tx_level, rx_level;
  logic [1:0] tx_sel, rx_sel;
  logic       rx_wvalid, rx_wready, frame_err, break_err;
  logic       we;
  logic [1:0] addr;
  logic [5:0] wdata, rdata, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fifo_irq_events uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .tx_level_i     (tx_level),
    .rx_level_i     (rx_level),
    .tx_thr_sel_i   (tx_sel),
    .rx_thr_sel_i   (rx_sel),
    .rx_wvalid_i    (rx_wvalid),
    .rx_wready_i    (rx_wready),
    .rx_frame_err_i (frame_err),
    .rx_break_err_i (break_err),
    .reg_we_i       (we),
    .reg_addr_i     (addr),
    .reg_wdata_i    (wdata),
    .reg_rdata_o    (rdata),
    .irq_o          (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [5:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [5:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic status_bit(input int b, output int v);
    logic [5:0] d;
    reg_read(2'd0, d);
    v = int'(d[b]);
  endtask

  task automatic clear_all();
    reg_write(2'd0, 6'h3f);
  endtask

  task automatic t_reset();
    int v;
    logic [5:0] d;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_read(2'd0, d);
    check("R7 reset status", int'(d), 0);
    check("R8 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    tick();
    status_bit(0, v);
    check("R2 no threshold event after reset", v, 0);
    status_bit(2, v);
    check("R3 empty event after reset", v, 1);
    clear_all();
    tick();
    reg_read(2'd0, d);
    check("R3 no repeat while empty", int'(d), 0);
  endtask

  task automatic t_tx_threshold();
    int v;
    for (int l = 0; l < 4; l++) begin
      int th;
      th = (l == 0) ? 1 : (1 << (l + 1));
      tx_sel = 2'(l); tx_level = 6'(th);
      tick(); tick();
      clear_all();
      status_bit(0, v);
      check("R1 level at threshold", v, 0);
      tx_level = 6'(th - 1);
      tick();
      status_bit(0, v);
      check("R1 crossing below threshold", v, 1);
      clear_all();
      if (th > 1) tx_level = 6'(th - 2);
      tick();
      status_bit(0, v);
      check("R1 no refire while below", v, 0);
    end
  endtask

  task automatic t_tx_empty();
    int v;
    tx_sel = 2'd0; tx_level = 6'd5;
    tick(); tick();
    clear_all();
    tx_level = 6'd0;
    tick();
    status_bit(2, v);
    check("R3 drain to zero", v, 1);
    clear_all();
    tick(); tick();
    status_bit(2, v);
    check("R3 stays clear while empty", v, 0);
    tx_level = 6'd1; tick();
    tx_level = 6'd0; tick();
    status_bit(2, v);
    check("R3 second drain", v, 1);
    tx_level = 6'd20;
    tick(); tick();
    clear_all();
  endtask

  task automatic t_registers();
    logic [5:0] d;
    reg_write(2'd1, 6'h05);
    reg_read(2'd1, d);
    check("R8 enable readback", int'(d), 'h05);
    check("R8 irq idle", int'(irq), 0);
    reg_write(2'd2, 6'h3f);
    reg_read(2'd0, d);
    check("R9 test sets all", int'(d), 'h3f);
    check("R8 irq masked", int'(irq), 'h05);
    reg_read(2'd2, d);
    check("R9 test reads zero", int'(d), 0);
    clear_all();
    reg_read(2'd0, d);
    check("R7 clear all", int'(d), 0);
    check("R8 irq after clear", int'(irq), 0);
    reg_write(2'd2, 6'h0a);
    reg_write(2'd0, 6'h02);
    reg_read(2'd0, d);
    check("R7 partial clear", int'(d), 'h08);
    clear_all();
  endtask

  task automatic t_overflow();
    int v;
    rx_wvalid = 1'b1; rx_wready = 1'b1;
    tick();
    status_bit(3, v);
    check("R5 accepted write", v, 0);
    rx_wready = 1'b0;
    tick();
    rx_wvalid = 1'b0;
    status_bit(3, v);
    check("R5 refused write", v, 1);
    check("R8 masked overflow line", int'(irq[3]), 0);
    clear_all();
    rx_wvalid = 1'b1;
    reg_write(2'd0, 6'h08);
    rx_wvalid = 1'b0; rx_wready = 1'b1;
    status_bit(3, v);
    check("R10 set beats clear", v, 1);
    clear_all();
    status_bit(3, v);
    check("R7 overflow cleared", v, 0);
  endtask

  task automatic t_line_errors();
    logic [5:0] d;
    frame_err = 1'b1; tick(); frame_err = 1'b0;
    reg_read(2'd0, d);
    check("R6 frame error", int'(d), 'h10);
    break_err = 1'b1; tick(); break_err = 1'b0;
    reg_read(2'd0, d);
    check("R6 break error", int'(d), 'h30);
    clear_all();
  endtask

  task automatic t_rx_threshold();
    int v;
    rx_sel = 2'd1; rx_level = 6'd3;
    tick(); clear_all();
    status_bit(1, v);
    check("R4 below level", v, 0);
    rx_level = 6'd4; tick();
    status_bit(1, v);
    check("R4 at level", v, 1);
    clear_all();
    status_bit(1, v);
    check("R4 resets after clear while held", v, 1);
    rx_sel = 2'd3; rx_level = 6'd15;
    tick(); clear_all();
    status_bit(1, v);
    check("R4 15 under 16", v, 0);
    rx_level = 6'd16; tick();
    status_bit(1, v);
    check("R4 16 reaches 16", v, 1);
    rx_level = 6'd0; clear_all();
    status_bit(1, v);
    check("R4 released", v, 0);
  endtask

  initial begin
    tx_level = '0; rx_level = '0; tx_sel = '0; rx_sel = '0;
    rx_wvalid = 1'b0; rx_wready = 1'b1; frame_err = 1'b0; break_err = 1'b0;
    we = 1'b0; addr = '0; wdata = '0;
    t_reset();
    t_tx_threshold();
    t_tx_empty();
    t_registers();
    t_overflow();
    t_line_errors();
    t_rx_threshold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule